// File: doc/BRIEF.md
# Sliced Arithmetic-Logic Unit with Four-Bit Function Code

This block is a purely combinational arithmetic-logic unit for a 32-bit datapath. Two operands and a 4-bit function code go in. A 32-bit result and a zero indication come out in the same cycle.

The datapath is a row of identical one-bit cells. Each cell can invert its A bit and its B bit. It forms AND, OR and a sum, and chooses one of these or a shared "less" input through a four-way select. The function code is split into three fields:

- bit 3 inverts A in every cell;
- bit 2 inverts B in every cell and also supplies the carry into the lowest cell;
- bits 1:0 pick the cell output.

Because one line feeds both the B inversion and the lowest carry-in, subtraction is addition of the one's complement plus one. NOR comes from the AND path with both operands inverted. Set-on-less-than routes the sign of the difference from the top cell back to bit 0.

The carries are produced by a separate generate/propagate chain fed by the cells. Codes outside the six defined ones force the result to zero.

A typical use is an instruction datapath that needs one adder for arithmetic, comparison and equality. Equality is tested by subtracting and reading the zero flag.

Top module: `alu_top`

## Requirements
- R1: Code 4'b0000 gives the bitwise AND of A and B.
- R2: Code 4'b0001 gives the bitwise OR of A and B.
- R3: Code 4'b0010 gives A+B modulo 2^32; any carry beyond bit 31 is dropped.
- R4: Code 4'b0110 gives A-B modulo 2^32, computed as A + ~B + 1.
- R5: Code 4'b0111 gives a result whose bit 0 equals bit 31 of (A-B modulo 2^32) and whose bits 31..1 are zero. Overflow is not corrected, so A=32'h80000000, B=1 yields 0.
- R6: Code 4'b1100 gives the bitwise NOR of A and B.
- R7: Every code other than 0000, 0001, 0010, 0110, 0111 and 1100 gives a result of all zeros, whatever the operands.
- R8: The zero flag is 1 exactly when all 32 result bits are 0. In particular, code 0110 with A equal to B sets it.
- R9: The outputs depend only on the present inputs, with no state. A new code and operands are reflected before the next clock edge of the surrounding logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| funcCode | input | 4 | Function code: bit 3 A-invert, bit 2 B-negate, bits 1:0 cell output select |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| result | output | 32 | Selected result |
| zero | output | 1 | High when result is all zeros |

## Verification
The hardest case to reach is set-on-less-than where the subtraction overflows. There, the sign of the wrapped difference disagrees with a true signed comparison. Uniform random operands hit it rarely with the right code.

The stimulus therefore walks every one of the sixteen codes over a fixed set of operand pairs. These pairs include both overflow directions (most-negative minus one, one minus most-negative), all-ones, equal operands and alternating patterns. A long random phase with mostly defined codes then follows.

Equal-operand subtraction is also injected on purpose to drive the zero flag high through the arithmetic path.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    FN_AND = 4'b0000,
    FN_OR  = 4'b0001,
    FN_ADD = 4'b0010,
    FN_SUB = 4'b0110,
    FN_SLT = 4'b0111,
    FN_NOR = 4'b1100
  } aluFunc_e;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } cellSel_e;

  typedef struct packed {
    logic     invertA;
    logic     negateB;
    cellSel_e cellSel;
    logic     resultEnable;
  } aluStrobes_t;

endpackage

// File: rtl/alu_control.sv
module alu_control
  import alu_pkg::*;
(
  input  logic [CODE_W-1:0] funcCode,
  output aluStrobes_t       strobes
);

  logic codeKnown;

  always_comb begin
    unique case (funcCode)
      FN_AND, FN_OR, FN_ADD, FN_SUB, FN_SLT, FN_NOR: codeKnown = 1'b1;
      default:                                       codeKnown = 1'b0;
    endcase
  end

  always_comb begin
    strobes.invertA      = funcCode[3];
    strobes.negateB      = funcCode[2];
    strobes.cellSel      = cellSel_e'(funcCode[1:0]);
    strobes.resultEnable = codeKnown;
  end

endmodule

// File: rtl/alu_cell.sv
module alu_cell
  import alu_pkg::*;
(
  input  logic     aBit,
  input  logic     bBit,
  input  logic     invertA,
  input  logic     negateB,
  input  logic     carryIn,
  input  logic     lessIn,
  input  cellSel_e cellSel,
  output logic     genBit,
  output logic     propBit,
  output logic     sumBit,
  output logic     resBit
);

  logic aEff;
  logic bEff;

  always_comb begin
    aEff    = aBit ^ invertA;
    bEff    = bBit ^ negateB;
    genBit  = aEff & bEff;
    propBit = aEff | bEff;
    sumBit  = aEff ^ bEff ^ carryIn;
    unique case (cellSel)
      SEL_AND:  resBit = genBit;
      SEL_OR:   resBit = propBit;
      SEL_SUM:  resBit = sumBit;
      SEL_LESS: resBit = lessIn;
      default:  resBit = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_carry_chain.sv
module alu_carry_chain #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] genVec,
  input  logic [WIDTH-1:0] propVec,
  input  logic             carryLow,
  output logic [WIDTH-1:0] carryVec
);

  logic unusedTopGp;
  assign unusedTopGp = genVec[WIDTH-1] ^ propVec[WIDTH-1];

  always_comb begin
    logic running;
    running     = carryLow;
    carryVec[0] = carryLow;
    for (int i = 1; i < WIDTH; i++) begin
      running     = genVec[i-1] | (propVec[i-1] & running);
      carryVec[i] = running;
    end
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             zero
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] genVec;
  logic [WIDTH-1:0] propVec;
  logic [WIDTH-1:0] sumVec;
  logic [WIDTH-1:0] rawVec;
  logic [WIDTH-1:0] carryVec;
  logic [WIDTH-1:0] lessVec;
  logic             signOfDiff;

  assign signOfDiff = sumVec[TOP];

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      if (i == 0) begin : g_low
        assign lessVec[i] = signOfDiff;
      end else begin : g_rest
        assign lessVec[i] = 1'b0;
      end

      alu_cell u_cell (
        .aBit    (opA[i]),
        .bBit    (opB[i]),
        .invertA (strobes.invertA),
        .negateB (strobes.negateB),
        .carryIn (carryVec[i]),
        .lessIn  (lessVec[i]),
        .cellSel (strobes.cellSel),
        .genBit  (genVec[i]),
        .propBit (propVec[i]),
        .sumBit  (sumVec[i]),
        .resBit  (rawVec[i])
      );
    end
  endgenerate

  alu_carry_chain #(.WIDTH(WIDTH)) u_chain (
    .genVec   (genVec),
    .propVec  (propVec),
    .carryLow (strobes.negateB),
    .carryVec (carryVec)
  );

  always_comb begin
    result = strobes.resultEnable ? rawVec : '0;
    zero   = ~|result;
  end

endmodule

// File: rtl/alu_top.sv
module alu_top
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       funcCode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output logic             zero
);

  aluStrobes_t strobes;

  alu_control u_ctrl (
    .funcCode (funcCode),
    .strobes  (strobes)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (result),
    .zero    (zero)
  );

endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
  parameter int WIDTH = 32
) (
  input logic [3:0]       funcCode,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [WIDTH-1:0] result,
  input logic             zero
);

  always_comb begin
    if (funcCode == 4'b0000) begin
      AST_AND_WITHIN_A: assert ((result & ~opA) == '0) else $error("and escapes A"); // R1
    end
    if (funcCode == 4'b0001) begin
      AST_OR_COVERS_B: assert ((result & opB) == opB) else $error("or drops B"); // R2
    end
    if (funcCode == 4'b0111) begin
      AST_SLT_UPPER_CLEAR: assert (result[WIDTH-1:1] == '0) else $error("slt upper bits"); // R5
    end
    if (funcCode == 4'b1100) begin
      AST_NOR_DISJOINT: assert ((result & (opA | opB)) == '0) else $error("nor overlaps"); // R6
    end
    if (!(funcCode inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100})) begin
      AST_UNDEFINED_ZERO: assert (result == '0 && zero) else $error("undefined code output"); // R7
    end
    if (funcCode == 4'b0110 && opA == opB) begin
      AST_SUB_EQUAL_ZERO: assert (zero && result == '0) else $error("equal sub not zero"); // R8
    end
  end

endmodule

bind alu_top alu_checker #(.WIDTH(WIDTH)) u_alu_checker (
  .funcCode (funcCode),
  .opA      (opA),
  .opB      (opB),
  .result   (result),
  .zero     (zero)
);

// File: tb/sim_alu_top.sv
module sim_alu_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  funcCode = 4'b0000;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [31:0] result;
  logic        zero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_top u0 (
    .funcCode (funcCode),
    .opA      (opA),
    .opB      (opB),
    .result   (result),
    .zero     (zero)
  );

  function automatic logic [31:0] refModel(logic [3:0] c, logic [31:0] a, logic [31:0] b);
    logic [31:0] diff;
    diff = a - b;
    case (c)
      4'b0000: return a & b;
      4'b0001: return a | b;
      4'b0010: return a + b;
      4'b0110: return diff;
      4'b0111: return {31'd0, diff[31]};
      4'b1100: return ~(a | b);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string reqOf(logic [3:0] c);
    case (c)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      4'b1100: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic applyAndCheck(logic [3:0] c, logic [31:0] a, logic [31:0] b, string extra);
    logic [31:0] expRes;
    logic        expZero;
    @(posedge clk);
    funcCode = c;
    opA = a;
    opB = b;
    expRes  = refModel(c, a, b);
    expZero = (expRes == 32'd0);
    @(negedge clk);
    checks++;
    if (result !== expRes) begin
      errors++;
      $display("FAIL %s%s code=%b a=%h b=%h actual=%h expected=%h",
               reqOf(c), extra, c, a, b, result, expRes);
    end
    checks++;
    if (zero !== expZero) begin
      errors++;
      $display("FAIL R8 zero code=%b a=%h b=%h actual=%b expected=%b",
               c, a, b, zero, expZero);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] pa [8];
    logic [31:0] pb [8];
    logic [3:0]  defined [6];
    pa = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1, 32'h7FFF_FFFF,
           32'h1234_5678, 32'hA5A5_A5A5, 32'hFFFF_FFFF};
    pb = '{32'h0, 32'hFFFF_FFFF, 32'h1, 32'h8000_0000, 32'h1,
           32'h1234_5678, 32'h5A5A_5A5A, 32'h1};
    defined = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};

    repeat (2) @(posedge clk);
    rstN = 1'b1;

    // Idle state: code 0000 with zero operands, R1 result 0 and R8 flag 1
    @(negedge clk);
    checks++;
    if (result !== 32'd0 || zero !== 1'b1) begin
      errors++;
      $display("FAIL R8 idle actual=%h/%b expected=00000000/1", result, zero);
    end

    // R9: combinational response, every code over corner operand pairs
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 8; k++) begin
        applyAndCheck(4'(c), pa[k], pb[k], " corner R9");
      end
    end

    // R5 overflow corner named explicitly
    applyAndCheck(4'b0111, 32'h8000_0000, 32'h1, " slt overflow");
    applyAndCheck(4'b0111, 32'h1, 32'h8000_0000, " slt overflow");
    // R3 carry beyond bit 31 dropped
    applyAndCheck(4'b0010, 32'hFFFF_FFFF, 32'h1, " add wrap");

    // R8: equal-operand subtraction forces zero high
    for (int k = 0; k < 50; k++) begin
      logic [31:0] v;
      v = $urandom;
      applyAndCheck(4'b0110, v, v, " R8 equal");
    end

    // Random phase, mostly defined codes
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] c;
      if ($urandom_range(0, 7) != 0) c = defined[$urandom_range(0, 5)];
      else c = 4'($urandom);
      applyAndCheck(c, $urandom, $urandom, " random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule